// File: doc/BRIEF.md
# Fine-Grain Thread Select Unit

This block sits at the front of a single-issue, in-order pipeline that is shared by four hardware threads. On every clock cycle it picks one thread to issue. It drives that thread's ID, its program counter and the oldest word from its instruction buffer, together with a valid flag. Because the pick can move to a different thread on each cycle, a thread that is waiting on memory, a trap or a shared unit simply drops out of the rotation. The other threads fill the slots it leaves, so its latency is hidden and no issue cycle is lost.

Each thread has its own program counter and a small first-in first-out instruction buffer. Fetch fills a buffer through a one-word fill port. Each issue removes the oldest word and advances that thread's counter by a fixed step. A redirect port loads a new counter value for one thread and empties that thread's buffer. Four per-thread block inputs mark a thread as not ready: pending cache miss, trap or interrupt in service, resource conflict, and a long-latency hint from decode. The unit registers these inputs, so a change on them takes effect one cycle later.

Top module: `thread_select_unit`

## Requirements
- R1: While reset is held and right after it is released, selValid is 0. Every PC holds ResetVec (default 0x100), every buffer is empty and the rotation pointer is thread 0.
- R2: Among the ready threads, the one granted is the first one met in the order pointer, pointer+1, and so on modulo 4. After a grant the pointer moves to the granted ID plus one, modulo 4. Consecutive cycles may grant different threads with no idle cycle between them.
- R3: A thread is blocked when missPend, trapBusy, rsrcBusy or longOpHint has its bit set (bit t is thread t). The block inputs are sampled at each clock edge. Setting a bit blocks the thread from the next cycle on, and clearing it makes the thread eligible again on the following cycle.
- R4: A thread whose instruction buffer is empty is never granted.
- R5: When no thread is ready, selValid is 0 and the pointer keeps its value.
- R6: With selValid high, selPc is the granted thread's PC. Each issue advances that thread's PC by PcStep (default 4) and leaves the other threads' PCs unchanged.
- R7: Each buffer holds BufDepth words (default 4) and issues them in fill order on selInstr. A fill for thread fillTid is accepted only while that buffer holds fewer than BufDepth words. A fill to a full buffer is dropped, even in a cycle in which that buffer issues.
- R8: A redirect loads redirPc into thread redirTid's PC and empties that thread's buffer. A fill to the same thread in the same cycle is dropped. Other threads are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| missPend | input | 4 | Per-thread cache miss pending |
| trapBusy | input | 4 | Per-thread trap or interrupt in service |
| rsrcBusy | input | 4 | Per-thread resource conflict |
| longOpHint | input | 4 | Per-thread long-latency hint from decode |
| fillValid | input | 1 | Fill strobe for an instruction buffer |
| fillTid | input | 2 | Thread whose buffer takes the fill word |
| fillInstr | input | InstrW | Fill word |
| redirValid | input | 1 | PC redirect strobe |
| redirTid | input | 2 | Thread being redirected |
| redirPc | input | PcW | New PC value |
| selValid | output | 1 | A thread issues this cycle |
| selTid | output | 2 | Granted thread ID |
| selPc | output | PcW | PC of the granted thread |
| selInstr | output | InstrW | Oldest buffered word of the granted thread |

## Verification
A pointer that ends up on the wrong thread shows on selTid within one or two issue cycles, as soon as two threads are ready together. An occupancy count that drifts shows either as a grant to a thread that has no words left or as a skip of a thread that still has words. Both appear on the first cycle in which that thread would be considered. A corrupted PC or buffer slot shows on selPc or selInstr the next time that thread issues, because every issue exposes both values. The bench models every thread's counter, occupancy and pointer and compares all four outputs on every cycle. A wrong state is therefore reported at the first cycle in which it becomes visible.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int ThreadCount = 4;
  localparam int TidW = $clog2(ThreadCount);

  typedef logic [ThreadCount-1:0] thread_vec_t;

  // control-to-datapath strobes: one issue per cycle at most
  typedef struct packed {
    logic            issue;
    logic [TidW-1:0] grantId;
    thread_vec_t     grantOh;
  } issue_strobe_t;
endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  thread_vec_t   stallIn,
  input  thread_vec_t   bufNotEmpty,
  output issue_strobe_t strobe
);
  thread_vec_t     stallQ;
  thread_vec_t     readyVec;
  logic [TidW-1:0] rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallQ <= '0;
    else       stallQ <= stallIn;
  end

  assign readyVec = bufNotEmpty & ~stallQ;

  // scan from the far end toward the pointer so the nearest ready thread wins
  always_comb begin
    thread_vec_t oh;
    strobe = '0;
    oh = '0;
    for (int k = ThreadCount - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(rrPtr) + k) % ThreadCount;
      if (readyVec[idx]) begin
        strobe.issue   = 1'b1;
        strobe.grantId = TidW'(idx);
      end
    end
    if (strobe.issue) oh[strobe.grantId] = 1'b1;
    strobe.grantOh = oh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.issue) begin
      rrPtr <= (int'(strobe.grantId) == ThreadCount - 1) ? '0 : strobe.grantId + 1'b1;
    end
  end
endmodule

// File: rtl/tsel_dpath.sv
module tsel_dpath
  import tsel_pkg::*;
#(
  parameter int          PcW      = 32,
  parameter int          InstrW   = 32,
  parameter int          BufDepth = 4,
  parameter logic [31:0] ResetVec = 32'h0000_0100,
  parameter int          PcStep   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  issue_strobe_t     strobe,
  input  logic              fillValid,
  input  logic [TidW-1:0]   fillTid,
  input  logic [InstrW-1:0] fillInstr,
  input  logic              redirValid,
  input  logic [TidW-1:0]   redirTid,
  input  logic [PcW-1:0]    redirPc,
  output thread_vec_t       bufNotEmpty,
  output logic [PcW-1:0]    selPc,
  output logic [InstrW-1:0] selInstr
);
  localparam int SlotW = (BufDepth > 1) ? $clog2(BufDepth) : 1;
  localparam int CntW  = $clog2(BufDepth + 1);

  logic [PcW-1:0]    pcQ     [ThreadCount];
  logic [SlotW-1:0]  rdQ     [ThreadCount];
  logic [SlotW-1:0]  wrQ     [ThreadCount];
  logic [CntW-1:0]   cntQ    [ThreadCount];
  logic [InstrW-1:0] bufMem  [ThreadCount][BufDepth];

  thread_vec_t popVec, pushVec, redirVec;

  function automatic logic [SlotW-1:0] nextSlot(input logic [SlotW-1:0] s);
    return (int'(s) == BufDepth - 1) ? '0 : s + 1'b1;
  endfunction

  for (genvar t = 0; t < ThreadCount; t++) begin : g_thr
    assign redirVec[t]    = redirValid && (redirTid == TidW'(t));
    assign popVec[t]      = strobe.grantOh[t];
    assign pushVec[t]     = fillValid && (fillTid == TidW'(t)) &&
                            (cntQ[t] != CntW'(BufDepth)) && !redirVec[t];
    assign bufNotEmpty[t] = (cntQ[t] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < ThreadCount; t++) begin
        pcQ[t]  <= PcW'(ResetVec);
        rdQ[t]  <= '0;
        wrQ[t]  <= '0;
        cntQ[t] <= '0;
      end
    end else begin
      for (int t = 0; t < ThreadCount; t++) begin
        if (redirVec[t]) begin
          pcQ[t]  <= redirPc;
          rdQ[t]  <= '0;
          wrQ[t]  <= '0;
          cntQ[t] <= '0;
        end else begin
          if (popVec[t]) begin
            pcQ[t] <= pcQ[t] + PcW'(PcStep);
            rdQ[t] <= nextSlot(rdQ[t]);
          end
          if (pushVec[t]) wrQ[t] <= nextSlot(wrQ[t]);
          cntQ[t] <= cntQ[t] + CntW'(pushVec[t]) - CntW'(popVec[t]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < ThreadCount; t++) begin
      if (pushVec[t]) bufMem[t][wrQ[t]] <= fillInstr;
    end
  end

  assign selPc    = pcQ[strobe.grantId];
  assign selInstr = bufMem[strobe.grantId][rdQ[strobe.grantId]];
endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit
  import tsel_pkg::*;
#(
  parameter int          PcW      = 32,
  parameter int          InstrW   = 32,
  parameter int          BufDepth = 4,
  parameter logic [31:0] ResetVec = 32'h0000_0100,
  parameter int          PcStep   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ThreadCount-1:0] missPend,
  input  logic [ThreadCount-1:0] trapBusy,
  input  logic [ThreadCount-1:0] rsrcBusy,
  input  logic [ThreadCount-1:0] longOpHint,
  input  logic                   fillValid,
  input  logic [TidW-1:0]        fillTid,
  input  logic [InstrW-1:0]      fillInstr,
  input  logic                   redirValid,
  input  logic [TidW-1:0]        redirTid,
  input  logic [PcW-1:0]         redirPc,
  output logic                   selValid,
  output logic [TidW-1:0]        selTid,
  output logic [PcW-1:0]         selPc,
  output logic [InstrW-1:0]      selInstr
);
  issue_strobe_t strobe;
  thread_vec_t   bufNotEmpty;
  thread_vec_t   stallIn;

  assign stallIn = missPend | trapBusy | rsrcBusy | longOpHint;

  tsel_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stallIn    (stallIn),
    .bufNotEmpty(bufNotEmpty),
    .strobe     (strobe)
  );

  tsel_dpath #(
    .PcW     (PcW),
    .InstrW  (InstrW),
    .BufDepth(BufDepth),
    .ResetVec(ResetVec),
    .PcStep  (PcStep)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fillValid  (fillValid),
    .fillTid    (fillTid),
    .fillInstr  (fillInstr),
    .redirValid (redirValid),
    .redirTid   (redirTid),
    .redirPc    (redirPc),
    .bufNotEmpty(bufNotEmpty),
    .selPc      (selPc),
    .selInstr   (selInstr)
  );

  assign selValid = strobe.issue;
  assign selTid   = strobe.grantId;
endmodule

// File: rtl/thread_select_chk.sv
module thread_select_chk
  import tsel_pkg::*;
#(
  parameter int PcW    = 32,
  parameter int PcStep = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ThreadCount-1:0] missPend,
  input logic [ThreadCount-1:0] trapBusy,
  input logic [ThreadCount-1:0] rsrcBusy,
  input logic [ThreadCount-1:0] longOpHint,
  input logic                   redirValid,
  input logic [TidW-1:0]        redirTid,
  input logic                   selValid,
  input logic [TidW-1:0]        selTid,
  input logic [PcW-1:0]         selPc
);
  thread_vec_t blockIn;
  logic        pastOk;

  assign blockIn = missPend | trapBusy | rsrcBusy | longOpHint;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_idle_R1: assert (!selValid);
  end

  assert_blocked_skip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && selValid) |-> ((($past(blockIn) >> selTid) & ThreadCount'(1)) == '0));

  assert_all_blocked_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && ($past(blockIn) == '1)) |-> !selValid);

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(selValid) && selValid && (selTid == $past(selTid)) &&
     !($past(redirValid) && ($past(redirTid) == selTid)))
    |-> (selPc == $past(selPc) + PcW'(PcStep)));

  assert_redirect_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(redirValid) |-> !(selValid && (selTid == $past(redirTid))));
endmodule

bind thread_select_unit thread_select_chk #(.PcW(PcW), .PcStep(PcStep)) chk_i (.*);

// File: tb/thread_select_unit_tb_top.sv
module thread_select_unit_tb_top;
  import tsel_pkg::*;

  localparam int          PcW    = 32;
  localparam int          InstrW = 32;
  localparam int          Depth  = 4;
  localparam int          Step   = 4;
  localparam logic [31:0] RVec   = 32'h0000_0100;
  localparam int          NT     = ThreadCount;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN = 1'b0;
  thread_vec_t       missPend = '0, trapBusy = '0, rsrcBusy = '0, longOpHint = '0;
  logic              fillValid = 1'b0;
  logic [TidW-1:0]   fillTid = '0;
  logic [InstrW-1:0] fillInstr = '0;
  logic              redirValid = 1'b0;
  logic [TidW-1:0]   redirTid = '0;
  logic [PcW-1:0]    redirPc = '0;
  logic              selValid;
  logic [TidW-1:0]   selTid;
  logic [PcW-1:0]    selPc;
  logic [InstrW-1:0] selInstr;

  thread_select_unit #(
    .PcW(PcW), .InstrW(InstrW), .BufDepth(Depth), .ResetVec(RVec), .PcStep(Step)
  ) dut_i (
    .clk(clk), .rstN(rstN), .missPend(missPend), .trapBusy(trapBusy),
    .rsrcBusy(rsrcBusy), .longOpHint(longOpHint), .fillValid(fillValid),
    .fillTid(fillTid), .fillInstr(fillInstr), .redirValid(redirValid),
    .redirTid(redirTid), .redirPc(redirPc), .selValid(selValid),
    .selTid(selTid), .selPc(selPc), .selInstr(selInstr)
  );

  int checks = 0;
  int errs   = 0;

  logic [31:0] mPc  [NT];
  logic [31:0] mBuf [NT][Depth];
  int          mCnt [NT];
  thread_vec_t mStall;
  int          mPtr;
  int          seq;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic predict(output bit v, output int g);
    v = 1'b0;
    g = 0;
    for (int k = 0; k < NT; k++) begin
      int i;
      i = (mPtr + k) % NT;
      if (!v && !mStall[i] && mCnt[i] != 0) begin
        v = 1'b1;
        g = i;
      end
    end
  endtask

  // one cycle: compare outputs at the negedge, drive inputs, advance the model
  task automatic cycle(string tag, thread_vec_t mi, thread_vec_t tr, thread_vec_t rs,
                       thread_vec_t lo, bit fv, int ft, bit rv, int rt, logic [31:0] rp);
    bit    v;
    int    g;
    string tg;
    logic [31:0] word;
    predict(v, g);
    tg = (tag != "") ? tag : (v ? "R2" : "R5");
    chk(tg, "selValid", 32'(selValid), 32'(v));
    if (v) begin
      chk(tg, "selTid", 32'(selTid), 32'(g));
      chk("R6", "selPc", selPc, mPc[g]);
      chk("R7", "selInstr", selInstr, mBuf[g][0]);
    end
    word = {8'(ft), 24'(seq)};
    missPend = mi; trapBusy = tr; rsrcBusy = rs; longOpHint = lo;
    fillValid = fv; fillTid = TidW'(ft); fillInstr = word;
    redirValid = rv; redirTid = TidW'(rt); redirPc = rp;
    for (int t = 0; t < NT; t++) begin
      bit pop, push;
      pop  = v && (g == t);
      push = fv && (ft == t) && (mCnt[t] < Depth);
      if (rv && rt == t) begin
        mPc[t]  = rp;
        mCnt[t] = 0;
      end else begin
        if (pop) begin
          for (int i = 0; i < Depth - 1; i++) mBuf[t][i] = mBuf[t][i + 1];
          mCnt[t]--;
          mPc[t] = mPc[t] + Step;
        end
        if (push) begin
          mBuf[t][mCnt[t]] = word;
          mCnt[t]++;
        end
      end
    end
    if (v) mPtr = (g + 1) % NT;
    mStall = mi | tr | rs | lo;
    seq++;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R2 got hung exp finish");
    summary();
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      mPc[t]  = RVec;
      mCnt[t] = 0;
    end
    mStall = '0;
    mPtr   = 0;
    seq    = 0;

    // R1: idle in reset
    repeat (3) @(negedge clk);
    chk("R1", "selValid in reset", 32'(selValid), 32'd0);
    rstN = 1'b1;
    cycle("R1", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);

    // R4: only thread 2 has words, so it is granted while the others stay empty
    cycle("R4", '0, '0, '0, '0, 1'b1, 2, 1'b0, 0, '0);
    cycle("R4", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);
    // R1: first issue of each remaining thread comes from the reset vector
    for (int t = 0; t < NT; t++) cycle("R1", '0, '0, '0, '0, 1'b1, t, 1'b0, 0, '0);
    repeat (4) cycle("R2", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);

    // R7: overfill thread 1 while every thread is blocked, then drain
    for (int i = 0; i < 6; i++) cycle("R5", '1, '0, '0, '0, 1'b1, 1, 1'b0, 0, '0);
    repeat (7) cycle("R7", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);

    // R3: sweep every block source on every thread, with set and clear cycles
    for (int t = 0; t < NT; t++) repeat (3) cycle("R3", '0, '0, '0, '0, 1'b1, t, 1'b0, 0, '0);
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < NT; t++) begin
        thread_vec_t b;
        b = thread_vec_t'(1 << t);
        cycle("R3", (s == 0) ? b : '0, (s == 1) ? b : '0, (s == 2) ? b : '0,
              (s == 3) ? b : '0, 1'b1, (seq % NT), 1'b0, 0, '0);
        cycle("R3", '0, '0, '0, '0, 1'b1, (seq % NT), 1'b0, 0, '0);
        cycle("R3", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);
      end
    end

    // R8: redirect each thread with a same-cycle fill to it
    for (int t = 0; t < NT; t++) begin
      repeat (2) cycle("R8", '0, '0, '0, '0, 1'b1, t, 1'b0, 0, '0);
      cycle("R8", '0, '0, '0, '0, 1'b1, t, 1'b1, t, 32'h0000_4000 + 32'(t << 8));
      cycle("R8", '0, '0, '0, '0, 1'b1, t, 1'b0, 0, '0);
      repeat (2) cycle("R8", '0, '0, '0, '0, 1'b0, 0, 1'b0, 0, '0);
    end

    // mixed traffic: light blocking, then heavy blocking
    for (int n = 0; n < 4000; n++) begin
      thread_vec_t mi, tr, rs, lo;
      int sh;
      sh = (n < 3000) ? 3 : 1;
      mi = thread_vec_t'($urandom) & thread_vec_t'($urandom >> sh) & thread_vec_t'($urandom >> 7);
      tr = thread_vec_t'($urandom) & thread_vec_t'($urandom >> sh) & thread_vec_t'($urandom >> 9);
      rs = thread_vec_t'($urandom) & thread_vec_t'($urandom >> sh) & thread_vec_t'($urandom >> 11);
      lo = thread_vec_t'($urandom) & thread_vec_t'($urandom >> sh) & thread_vec_t'($urandom >> 13);
      if (n >= 3000) begin
        mi = thread_vec_t'($urandom);
        tr = thread_vec_t'($urandom) & thread_vec_t'($urandom);
      end
      cycle("", mi, tr, rs, lo, bit'($urandom % 2), int'($urandom % NT),
            ($urandom % 32) == 0, int'($urandom % NT), $urandom & 32'hFFFF_FFFC);
    end

    summary();
    $finish;
  end
endmodule